// File: doc/BRIEF.md
# DMA Control Register with Guarded Software Reset

This block holds the 16-bit control word of a DMA controller that also contains a CRC engine. A simple register port gives single-cycle reads and writes, with an error flag that is valid in the same cycle as the access. The register drives three sets of outputs:

- a mask of enabled priority levels, which the arbiter uses to ignore requests on disabled levels;
- the DMA engine enable;
- the CRC engine enable.

Turning either engine off is not always immediate. A cleared DMA enable stays set while a transfer is running, until the current beat finishes. A cleared CRC enable stays set while the CRC reports busy. Writing bit 0 asks for a software reset of the whole controller. The request is granted only when both engines are already off. When granted, it clears this register and raises a one-cycle reset pulse to the controller's other registers; the debug control register is not driven by that pulse. A refused request changes nothing and returns an error.

A write-protect input models the upstream protection logic. While it is high, writes are dropped and flagged as errors.

Top module: `dma_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x0000. Bits 15:12 and 7:3 always read 0, whatever was written to them.
- R2: Bits 11:8 hold the enables for priority levels 3 down to 0. They read back as written and drive `lvl_en_o` (bit 8 is `lvl_en_o[0]`).
- R3: Writing 1 to bit 1 (DMA enable) sets it in the next cycle. Writing 0 while `xfer_active` is low clears it in the next cycle, with no abort pulse.
- R4: Writing 0 to bit 1 while `xfer_active` is high and `beat_done` is low leaves bit 1 set. It clears at the edge on which `beat_done` is high or `xfer_active` is low. If a transfer was active at that edge, `xfer_abort_o` is high for the one following cycle, together with `dma_en_o` low.
- R5: Writing 1 to bit 2 (CRC enable) sets it in the next cycle. Writing 0 leaves it set while `crc_busy` is high, and it clears at the first edge with `crc_busy` low.
- R6: A pending deferred clear of bit 1 or bit 2 is cancelled by a write of 1 to that bit before the clear is applied.
- R7: A write with bit 0 set while bits 1 and 2 are both 0 is accepted without error. All other bits of that write are discarded, and the register is cleared. For exactly the next cycle, bit 0 reads 1 and `soft_rst_o` is high; both then return to 0.
- R8: A write with bit 0 set while bit 1 or bit 2 is 1 returns `bus_err`, changes no bit and raises no `soft_rst_o`.
- R9: A write with bit 0 clear never starts a reset: bit 0 reads 0 and `soft_rst_o` stays low.
- R10: While `wr_protect` is high, writes change nothing and return `bus_err`. Reads never return `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| bus_err | output | 1 | Error response for the current access |
| wr_protect | input | 1 | Blocks writes when high |
| xfer_active | input | 1 | A DMA transfer is in progress |
| beat_done | input | 1 | The current beat has finished and the internal buffer is empty |
| crc_busy | input | 1 | The CRC engine is computing |
| lvl_en_o | output | 4 | Priority-level enable mask for the arbiter |
| dma_en_o | output | 1 | DMA engine enable |
| crc_en_o | output | 1 | CRC engine enable |
| xfer_abort_o | output | 1 | One-cycle pulse when a deferred DMA disable aborts a transfer |
| soft_rst_o | output | 1 | One-cycle reset pulse to the controller's other registers |

## Verification
The assertions check, on every cycle, the safety rules of this block:

- an enable never drops while its engine is still busy;
- a refused reset raises an error and no pulse;
- protected writes leave the level mask untouched;
- reads never error;
- the reset pulse lasts one cycle and comes only with all enables clear.

Only the bench's scenarios show the rest:

- the deferred clear actually arrives once the beat ends or busy falls;
- a cancel write keeps the enable set;
- the discarded bits of a reset write;
- the exact readback values after each access.

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg #(
  parameter int DW      = 16,
  parameter int LEVELS  = 4,
  parameter int LVL_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic              wr_protect,
  input  logic              xfer_active,
  input  logic              beat_done,
  input  logic              crc_busy,
  output logic [LEVELS-1:0] lvl_en_o,
  output logic              dma_en_o,
  output logic              crc_en_o,
  output logic              xfer_abort_o,
  output logic              soft_rst_o
);
  localparam int BIT_SRST = 0;
  localparam int BIT_DMA  = 1;
  localparam int BIT_CRC  = 2;

  logic [LEVELS-1:0] lvl_q;
  logic dma_q, crc_q, srst_q, abort_q, dma_pend, crc_pend;

  wire wr_any     = bus_sel & bus_we;
  wire wr_open    = wr_any & ~wr_protect;
  wire srst_req   = wr_open & bus_wdata[BIT_SRST];
  wire engines_on = dma_q | crc_q;
  wire srst_ok    = srst_req & ~engines_on;
  wire wr_ok      = wr_open & ~bus_wdata[BIT_SRST];
  wire dma_set    = wr_ok & bus_wdata[BIT_DMA];
  wire crc_set    = wr_ok & bus_wdata[BIT_CRC];
  wire dma_off    = (wr_ok & ~bus_wdata[BIT_DMA] & dma_q) | dma_pend;
  wire crc_off    = (wr_ok & ~bus_wdata[BIT_CRC] & crc_q) | crc_pend;

  assign bus_err = (wr_any & wr_protect) | (srst_req & engines_on);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    bus_rdata[LVL_LSB +: LEVELS] = lvl_q;
    bus_rdata[BIT_CRC]  = crc_q;
    bus_rdata[BIT_DMA]  = dma_q;
    bus_rdata[BIT_SRST] = srst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0; dma_q <= 1'b0; crc_q <= 1'b0; srst_q <= 1'b0;
      abort_q <= 1'b0; dma_pend <= 1'b0; crc_pend <= 1'b0;
    end else begin
      srst_q  <= srst_ok;
      abort_q <= 1'b0;
      if (srst_ok) begin
        lvl_q <= '0; dma_q <= 1'b0; crc_q <= 1'b0;
        dma_pend <= 1'b0; crc_pend <= 1'b0;
      end else begin
        if (wr_ok) lvl_q <= bus_wdata[LVL_LSB +: LEVELS];

        if (dma_set) begin
          dma_q <= 1'b1; dma_pend <= 1'b0;
        end else if (dma_off) begin
          if (xfer_active && !beat_done) dma_pend <= 1'b1;
          else begin
            dma_q <= 1'b0; dma_pend <= 1'b0; abort_q <= xfer_active;
          end
        end

        if (crc_set) begin
          crc_q <= 1'b1; crc_pend <= 1'b0;
        end else if (crc_off) begin
          if (crc_busy) crc_pend <= 1'b1;
          else begin
            crc_q <= 1'b0; crc_pend <= 1'b0;
          end
        end
      end
    end
  end

  assign lvl_en_o     = lvl_q;
  assign dma_en_o     = dma_q;
  assign crc_en_o     = crc_q;
  assign xfer_abort_o = abort_q;
  assign soft_rst_o   = srst_q;

  assert_dma_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en_o && xfer_active && !beat_done) |=> dma_en_o);
  assert_abort_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort_o |-> !dma_en_o);
  assert_crc_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_en_o && crc_busy) |=> crc_en_o);
  assert_pulse_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (lvl_en_o == '0 && !dma_en_o && !crc_en_o));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && !(bus_sel && bus_we && bus_wdata[BIT_SRST])) |=> !soft_rst_o);
  assert_refused_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !wr_protect && bus_wdata[BIT_SRST] && (dma_en_o || crc_en_o))
    |-> bus_err);
  assert_refused_nopulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !wr_protect && bus_wdata[BIT_SRST] && (dma_en_o || crc_en_o))
    |=> !soft_rst_o);
  assert_protect_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && wr_protect) |=> ($stable(lvl_en_o) && !soft_rst_o));
  assert_read_noerr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |-> !bus_err);
endmodule

// File: tb/dma_ctrl_reg_bench.sv
module dma_ctrl_reg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0, wr_protect = 0, xfer_active = 0, beat_done = 0, crc_busy = 0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic bus_err, dma_en_o, crc_en_o, xfer_abort_o, soft_rst_o;
  logic [3:0] lvl_en_o;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { bit we; logic [15:0] rd; bit err; string tag; } item_t;
  item_t expq[$];

  always #4 clk = ~clk;

  dma_ctrl_reg u_dma_ctrl_reg (.*);

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [15:0] d, input logic [15:0] rd,
                     input bit err, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_wdata = d;
    it.we = we; it.rd = rd; it.err = err; it.tag = tag;
    expq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = '0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_sel) begin
        item_t it;
        it = expq.pop_front();
        chk({15'd0, bus_err}, {15'd0, it.err}, {it.tag, " err"});
        if (!it.we) chk(bus_rdata, it.rd, {it.tag, " rdata"});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk({12'd0, lvl_en_o}, 16'h0, "R1 reset lvl");
    chk({13'd0, crc_en_o, dma_en_o, soft_rst_o}, 16'h0, "R1 reset enables");
    acc(0, 16'h0, 16'h0000, 0, "R1 reset read");
    // R7 accepted reset, other bits discarded
    acc(1, 16'hFFFF, 16'h0, 0, "R7 accept");
    acc(0, 16'h0, 16'h0001, 0, "R7 in progress");
    chk({15'd0, soft_rst_o}, 16'h1, "R7 pulse");
    acc(0, 16'h0, 16'h0000, 0, "R7 self clear");
    chk({15'd0, soft_rst_o}, 16'h0, "R7 pulse end");
    // R2 levels
    acc(1, 16'h0A00, 16'h0, 0, "R2 write");
    acc(0, 16'h0, 16'h0A00, 0, "R2 read");
    chk({12'd0, lvl_en_o}, 16'h000A, "R2 mask");
    acc(1, 16'hF0F8, 16'h0, 0, "R1 write unused");
    acc(0, 16'h0, 16'h0000, 0, "R1 unused read");
    // R3 immediate set and clear
    acc(1, 16'h0F02, 16'h0, 0, "R3 set");
    acc(0, 16'h0, 16'h0F02, 0, "R3 set read");
    acc(1, 16'h0F00, 16'h0, 0, "R3 clear");
    acc(0, 16'h0, 16'h0F00, 0, "R3 clear read");
    chk({14'd0, xfer_abort_o, dma_en_o}, 16'h0, "R3 no abort");
    // R4 deferred DMA clear
    acc(1, 16'h0002, 16'h0, 0, "R4 set");
    xfer_active = 1;
    acc(1, 16'h0000, 16'h0, 0, "R4 deferred write");
    acc(0, 16'h0, 16'h0002, 0, "R4 held");
    idle(); idle();
    chk({15'd0, dma_en_o}, 16'h1, "R4 still on");
    beat_done = 1;
    idle();
    beat_done = 0; xfer_active = 0;
    chk({14'd0, xfer_abort_o, dma_en_o}, 16'h2, "R4 cleared with abort");
    idle();
    chk({15'd0, xfer_abort_o}, 16'h0, "R4 abort one cycle");
    // R8 refused reset
    acc(1, 16'h0002, 16'h0, 0, "R8 set");
    acc(1, 16'h0F01, 16'h0, 1, "R8 refused");
    acc(0, 16'h0, 16'h0002, 0, "R8 unchanged");
    chk({15'd0, soft_rst_o}, 16'h0, "R8 no pulse");
    // R6 cancel pending clear
    xfer_active = 1;
    acc(1, 16'h0000, 16'h0, 0, "R6 pend");
    acc(1, 16'h0002, 16'h0, 0, "R6 cancel");
    xfer_active = 0;
    idle(); idle();
    acc(0, 16'h0, 16'h0002, 0, "R6 kept");
    chk({15'd0, xfer_abort_o}, 16'h0, "R6 no abort");
    acc(1, 16'h0000, 16'h0, 0, "R3 idle clear");
    acc(0, 16'h0, 16'h0000, 0, "R3 idle clear read");
    // R5 deferred CRC clear
    acc(1, 16'h0004, 16'h0, 0, "R5 set");
    acc(0, 16'h0, 16'h0004, 0, "R5 set read");
    crc_busy = 1;
    acc(1, 16'h0000, 16'h0, 0, "R5 deferred write");
    acc(0, 16'h0, 16'h0004, 0, "R5 held");
    idle();
    chk({15'd0, crc_en_o}, 16'h1, "R5 still on");
    crc_busy = 0;
    idle();
    chk({15'd0, crc_en_o}, 16'h0, "R5 cleared");
    acc(0, 16'h0, 16'h0000, 0, "R5 cleared read");
    // R10 write protect
    wr_protect = 1;
    acc(1, 16'h0F06, 16'h0, 1, "R10 blocked");
    acc(0, 16'h0, 16'h0000, 0, "R10 read allowed");
    idle();
    wr_protect = 0;
    chk({12'd0, lvl_en_o}, 16'h0, "R10 mask unchanged");
    // R9 bit 0 clear
    acc(1, 16'h0300, 16'h0, 0, "R9 write");
    acc(0, 16'h0, 16'h0300, 0, "R9 read");
    chk({15'd0, soft_rst_o}, 16'h0, "R9 no pulse");
    idle(); idle();
    finish_run();
  end
endmodule